// File: doc/BRIEF.md
# Capture/Compare General Purpose Timer

A single 16-bit timer channel. It holds an up-counter that advances on every clock in which its count-enable input is high, and a reference register that it compares the counter against. When the two agree in an enabled cycle, the channel drives its output pin either as a one-clock low pulse or as an inversion of the current level, chosen by a mode bit. A programmable transition on the input pin copies the counter into a capture register. Both kinds of event set sticky flags, and each flag can be routed to a shared interrupt line.

Software reaches the channel through a small flat register port: a write strobe with address and data, and a combinational read mux. The channel also brings out a one-clock compare strobe. Feed it into the count enable of a second channel and the two form a 32-bit timer. The low channel runs in restart mode and its reference sets the division ratio.

Top module: `gp_timer_chan`

## Requirements
- R1: After reset, tout is 1 and irq and cmp_out are 0. Counter, capture, control and flags read 0, and the reference reads 0xFFFF.
- R2: The counter adds 1 on each clock with cnt_en high, holds when it is low, and wraps from 0xFFFF to 0. A write to address 4 loads it, and the load takes priority over counting.
- R3: A match is a cycle with cnt_en high and the counter equal to the reference (address 1). cmp_out is high during exactly the cycle after each match.
- R4: With control bit 0 clear, tout goes low for the one cycle after a match and is high otherwise.
- R5: With control bit 0 set, tout inverts in the cycle after each match and otherwise keeps its level.
- R6: With control bit 3 set, the counter is 0 in the cycle after a match. With it clear, counting goes on past the reference.
- R7: Control bits 2:1 choose the capture transition on tin: 0 none, 1 rising, 2 falling, 3 both. tin passes through two synchronizer flops and is compared with its previous synchronized sample. On a detected transition, address 2 loads the counter value of that cycle.
- R8: Event register (address 3): bit 0 is set by a match and bit 1 by a capture. Writing 1 to a bit clears it. A set in the same cycle as a clear leaves the bit set.
- R9: irq is high exactly when (flag bit 0 and control bit 4) or (flag bit 1 and control bit 5).
- R10: With one channel's cmp_out driving a second channel's cnt_en, the second channel's counter equals the number of matches the first channel made.
- R11: rd_data shows control (address 0, bits 5:0), reference (1), capture (2), events (3) and counter (4), zero-extended. Writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count enable, or cascade strobe from another channel |
| tin | input | 1 | Capture input pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| tout | output | 1 | Compare output pin |
| cmp_out | output | 1 | One-cycle compare strobe for cascading |
| irq | output | 1 | Interrupt request, active high |

## Verification
The properties assume that only one write reaches the channel per clock, and that the counter and the reference do not change between a match and the next edge except through the write port. The timing checks also assume tin reaches the edge detector only through the synchronizer. The stimulus changes every input just after a rising edge and holds it for a full cycle. It writes one register at a time and keeps reference and counter values small, so that matches, restarts and captures come often. Directed sequences place a flag clear on the very edge of a match and run the counter through the wrap.

// File: rtl/gptm_pkg.sv
package gptm_pkg;

   localparam int ADDR_W = 3;
   localparam int CTRL_W = 6;
   localparam int NUM_FLG = 2;

   localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_REF  = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_CAP  = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_EVT  = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd4;

   localparam int FLG_REF = 0;
   localparam int FLG_CAP = 1;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_ANY  = 2'd3
   } edge_sel_e;

   typedef struct packed {
      logic      ie_cap;
      logic      ie_ref;
      logic      restart;
      edge_sel_e edge_sel;
      logic      out_toggle;
   } ctrl_t;

endpackage

// File: rtl/gptm_edge_det.sv
module gptm_edge_det
   import gptm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  edge_sel_e sel,
   output logic      edge_ev
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;
   logic                   rise;
   logic                   fall;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gptm_edge_det: SYNC_STAGES must be at least 2");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   assign cur = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cur;
   end

   assign rise = cur & ~prev_q;
   assign fall = ~cur & prev_q;

   always_comb begin
      unique case (sel)
         EDGE_RISE: edge_ev = rise;
         EDGE_FALL: edge_ev = fall;
         EDGE_ANY:  edge_ev = rise | fall;
         default:   edge_ev = 1'b0;
      endcase
   end

endmodule

// File: rtl/gptm_counter.sv
module gptm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic [CNT_W-1:0] ref_val,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("gptm_counter: CNT_W must be at least 8");
      end
   endgenerate

   assign hit = en && (cnt == ref_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (ld) begin
         cnt <= ld_val;
      end else if (en) begin
         if (restart && hit) cnt <= '0;
         else                cnt <= cnt + ONE;
      end
   end

endmodule

// File: rtl/gptm_out_gen.sv
module gptm_out_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic toggle_mode,
   output logic tout,
   output logic cmp_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tout    <= 1'b1;
         cmp_out <= 1'b0;
      end else begin
         cmp_out <= hit;
         if (!toggle_mode) tout <= ~hit;
         else if (hit)     tout <= ~tout;
      end
   end

endmodule

// File: rtl/gptm_events.sv
module gptm_events #(
   parameter int NFLG = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NFLG-1:0] set,
   input  logic [NFLG-1:0] clr,
   input  logic [NFLG-1:0] ie,
   output logic [NFLG-1:0] flags,
   output logic            irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr) | set;
   end

   assign irq = |(flags & ie);

endmodule

// File: rtl/gp_timer_chan.sv
module gp_timer_chan
   import gptm_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              tin,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              tout,
   output logic              cmp_out,
   output logic              irq
);

   localparam logic [CNT_W-1:0] REF_RST = '1;

   generate
      if (CNT_W < CTRL_W) begin : g_bad_data
         $error("gp_timer_chan: CNT_W too narrow for control register");
      end
   endgenerate

   ctrl_t              ctrl_q;
   logic [CNT_W-1:0]   ref_q;
   logic [CNT_W-1:0]   cap_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [NUM_FLG-1:0] flags;
   logic [NUM_FLG-1:0] flg_set;
   logic [NUM_FLG-1:0] flg_clr;
   logic [NUM_FLG-1:0] flg_ie;
   logic               hit;
   logic               cap_ev;
   logic               wr_ctrl;
   logic               wr_ref;
   logic               wr_evt;
   logic               wr_cnt;

   assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
   assign wr_ref  = wr_en && (wr_addr == ADR_REF);
   assign wr_evt  = wr_en && (wr_addr == ADR_EVT);
   assign wr_cnt  = wr_en && (wr_addr == ADR_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ref_q  <= REF_RST;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_ref)  ref_q  <= wr_data;
      end
   end

   gptm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cnt_en),
      .restart (ctrl_q.restart),
      .ref_val (ref_q),
      .ld      (wr_cnt),
      .ld_val  (wr_data),
      .cnt     (cnt_q),
      .hit     (hit)
   );

   gptm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (tin),
      .sel     (ctrl_q.edge_sel),
      .edge_ev (cap_ev)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (cap_ev) cap_q <= cnt_q;
   end

   gptm_out_gen u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit         (hit),
      .toggle_mode (ctrl_q.out_toggle),
      .tout        (tout),
      .cmp_out     (cmp_out)
   );

   always_comb begin
      flg_set          = '0;
      flg_set[FLG_REF] = hit;
      flg_set[FLG_CAP] = cap_ev;
      flg_ie           = '0;
      flg_ie[FLG_REF]  = ctrl_q.ie_ref;
      flg_ie[FLG_CAP]  = ctrl_q.ie_cap;
      flg_clr          = wr_evt ? wr_data[NUM_FLG-1:0] : '0;
   end

   gptm_events #(.NFLG(NUM_FLG)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flg_set),
      .clr   (flg_clr),
      .ie    (flg_ie),
      .flags (flags),
      .irq   (irq)
   );

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         ADR_CTRL: rd_data[CTRL_W-1:0]  = ctrl_q;
         ADR_REF:  rd_data              = ref_q;
         ADR_CAP:  rd_data              = cap_q;
         ADR_EVT:  rd_data[NUM_FLG-1:0] = flags;
         ADR_CNT:  rd_data              = cnt_q;
         default:  rd_data              = '0;
      endcase
   end

endmodule

// File: rtl/gptm_chk.sv
module gptm_chk
   import gptm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cnt_en,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [CNT_W-1:0]   wr_data,
   input logic [CNT_W-1:0]   cnt,
   input logic [CNT_W-1:0]   ref_val,
   input ctrl_t              ctrl,
   input logic [CNT_W-1:0]   cap,
   input logic [NUM_FLG-1:0] flags,
   input logic               cap_ev,
   input logic               tout,
   input logic               cmp_out,
   input logic               irq
);

   logic match;
   logic ld;
   assign match = cnt_en && (cnt == ref_val);
   assign ld    = wr_en && (wr_addr == ADR_CNT);

   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !ld && !(ctrl.restart && match)) |=> (cnt == $past(cnt) + CNT_W'(1)));

   a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !ld) |=> $stable(cnt));

   a_r3_strobe_after_match: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> cmp_out);

   a_r3_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !match |=> !cmp_out);

   a_r4_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.out_toggle && match) |=> !tout);

   a_r5_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.out_toggle && match) |=> (tout != $past(tout)));

   a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.restart && match && !ld) |=> (cnt == '0));

   a_r7_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev |=> (cap == $past(cnt)));

   a_r8_ref_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[FLG_REF] && !(wr_en && wr_addr == ADR_EVT && wr_data[FLG_REF])) |=> flags[FLG_REF]);

   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev |=> flags[FLG_CAP]);

   a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags != '0));

endmodule

bind gp_timer_chan gptm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cnt_en  (cnt_en),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .cnt     (cnt_q),
   .ref_val (ref_q),
   .ctrl    (ctrl_q),
   .cap     (cap_q),
   .flags   (flags),
   .cap_ev  (cap_ev),
   .tout    (tout),
   .cmp_out (cmp_out),
   .irq     (irq)
);

// File: tb/gp_timer_chan_bench.sv
module gp_timer_chan_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        tin = 1'b0;
   logic        wr_en = 1'b0;
   logic        hi_wr = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data, hi_rd;
   logic        tout, cmp_out, irq, hi_tout, hi_cmp, hi_irq;
   logic        run_chk = 1'b0;

   int nchk = 0;
   int nerr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gp_timer_chan u_gp_timer_chan (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tin(tin),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .tout(tout), .cmp_out(cmp_out), .irq(irq)
   );

   gp_timer_chan u_hi (
      .clk(clk), .rst_n(rst_n), .cnt_en(cmp_out), .tin(1'b0),
      .wr_en(hi_wr), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(hi_rd),
      .tout(hi_tout), .cmp_out(hi_cmp), .irq(hi_irq)
   );

   // reference model of the low channel, built from the requirements
   logic [15:0] m_cnt, m_ref, m_cap;
   logic [5:0]  m_ctrl;
   logic [1:0]  m_flg;
   logic        m_tout, m_cmp;
   logic [2:0]  m_s;
   int          m_hits;
   logic        h_hit, h_rise, h_fall, h_cev;
   logic [1:0]  h_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= '0; m_ref <= 16'hFFFF; m_cap <= '0; m_ctrl <= '0;
         m_flg <= '0; m_tout <= 1'b1; m_cmp <= 1'b0; m_s <= '0; m_hits <= 0;
      end else begin
         h_hit  = cnt_en && (m_cnt == m_ref);
         h_rise = m_s[1] & ~m_s[2];
         h_fall = ~m_s[1] & m_s[2];
         case (m_ctrl[2:1])
            2'd1:    h_cev = h_rise;
            2'd2:    h_cev = h_fall;
            2'd3:    h_cev = h_rise | h_fall;
            default: h_cev = 1'b0;
         endcase
         h_clr = (wr_en && wr_addr == 3'd3) ? wr_data[1:0] : 2'b00;
         m_s <= {m_s[1:0], tin};
         if (wr_en && wr_addr == 3'd4) m_cnt <= wr_data;
         else if (cnt_en) m_cnt <= (m_ctrl[3] && h_hit) ? 16'd0 : m_cnt + 16'd1;
         if (wr_en && wr_addr == 3'd0) m_ctrl <= wr_data[5:0];
         if (wr_en && wr_addr == 3'd1) m_ref <= wr_data;
         if (h_cev) m_cap <= m_cnt;
         m_cmp <= h_hit;
         if (!m_ctrl[0]) m_tout <= ~h_hit;
         else if (h_hit) m_tout <= ~m_tout;
         m_flg <= (m_flg & ~h_clr) | {h_cev, h_hit};
         if (hi_wr && wr_addr == 3'd4) m_hits <= 0;
         else if (h_hit) m_hits <= m_hits + 1;
      end
   end

   function automatic logic [15:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0:    return {10'd0, m_ctrl};
         3'd1:    return m_ref;
         3'd2:    return m_cap;
         3'd3:    return {14'd0, m_flg};
         3'd4:    return m_cnt;
         default: return 16'd0;
      endcase
   endfunction

   function automatic logic exp_irq();
      return (m_flg[0] & m_ctrl[4]) | (m_flg[1] & m_ctrl[5]);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (run_chk) begin
         chk("R3 cmp_out", {31'd0, cmp_out}, {31'd0, m_cmp});
         chk("R4 R5 tout", {31'd0, tout}, {31'd0, m_tout});
         chk("R9 irq", {31'd0, irq}, {31'd0, exp_irq()});
         case (rd_addr)
            3'd2:    chk("R7 capture read", {16'd0, rd_data}, {16'd0, exp_rd(rd_addr)});
            3'd3:    chk("R8 event read", {16'd0, rd_data}, {16'd0, exp_rd(rd_addr)});
            3'd4:    chk("R2 R6 counter read", {16'd0, rd_data}, {16'd0, exp_rd(rd_addr)});
            default: chk("R11 register read", {16'd0, rd_data}, {16'd0, exp_rd(rd_addr)});
         endcase
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
   end

   initial begin
      void'($urandom(32'd20250611));
      // R1: reset state
      repeat (3) step();
      @(negedge clk);
      chk("R1 tout", {31'd0, tout}, 32'd1);
      chk("R1 irq", {31'd0, irq}, 32'd0);
      chk("R1 cmp_out", {31'd0, cmp_out}, 32'd0);
      for (int a = 0; a < 5; a++) begin
         rd_addr = 3'(a);
         #1;
         chk("R1 register", {16'd0, rd_data}, (a == 1) ? 32'h0000FFFF : 32'd0);
      end
      rd_addr = 3'd4;
      step();
      rst_n = 1'b1;
      step();
      run_chk = 1'b1;

      // R2: wrap past 0xFFFF with reference at 1, no restart
      wr(3'd1, 16'd1);
      wr(3'd4, 16'hFFFD);
      cnt_en = 1'b1;
      repeat (4) step();
      @(negedge clk);
      chk("R2 wrap", {16'd0, rd_data}, 32'd1);
      step();
      @(negedge clk);
      chk("R3 match strobe", {31'd0, cmp_out}, 32'd1);
      chk("R4 pulse low", {31'd0, tout}, 32'd0);
      step();
      @(negedge clk);
      chk("R4 pulse ends", {31'd0, tout}, 32'd1);
      chk("R6 no restart", {16'd0, rd_data}, 32'd3);
      cnt_en = 1'b0;

      // R5 and R6: toggle with restart, reference 2
      wr(3'd0, 16'h000F);
      wr(3'd1, 16'd2);
      wr(3'd4, 16'd0);
      cnt_en = 1'b1;
      repeat (3) step();
      @(negedge clk);
      chk("R5 toggled", {31'd0, tout}, 32'd0);
      chk("R6 restart zero", {16'd0, rd_data}, 32'd0);
      repeat (3) step();
      @(negedge clk);
      chk("R5 toggled back", {31'd0, tout}, 32'd1);
      cnt_en = 1'b0;

      // R8: set and clear on the same edge
      wr(3'd0, 16'h0018);
      wr(3'd1, 16'd5);
      wr(3'd4, 16'd4);
      cnt_en = 1'b1;
      wr(3'd3, 16'd1);
      wr(3'd3, 16'd3);
      cnt_en = 1'b0;
      rd_addr = 3'd3;
      @(negedge clk);
      chk("R8 set wins", {16'd0, rd_data}, 32'd1);
      chk("R9 irq enabled", {31'd0, irq}, 32'd1);
      wr(3'd3, 16'd1);
      @(negedge clk);
      chk("R8 clear", {16'd0, rd_data}, 32'd0);

      // R7: edge selection
      wr(3'd0, 16'h0022);
      wr(3'd4, 16'h1234);
      tin = 1'b1;
      repeat (4) step();
      rd_addr = 3'd2;
      @(negedge clk);
      chk("R7 rising capture", {16'd0, rd_data}, 32'h1234);
      wr(3'd0, 16'h0004);
      wr(3'd4, 16'h0055);
      tin = 1'b0;
      repeat (4) step();
      @(negedge clk);
      chk("R7 falling capture", {16'd0, rd_data}, 32'h0055);
      wr(3'd0, 16'h0000);
      wr(3'd4, 16'h0777);
      tin = 1'b1;
      repeat (4) step();
      tin = 1'b0;
      repeat (4) step();
      @(negedge clk);
      chk("R7 none ignores", {16'd0, rd_data}, 32'h0055);
      wr(3'd2, 16'hBEEF);
      @(negedge clk);
      chk("R11 capture read-only", {16'd0, rd_data}, 32'h0055);

      // R10: cascade into the second channel
      wr(3'd0, 16'h0008);
      wr(3'd1, 16'd3);
      wr(3'd4, 16'd0);
      hi_wr = 1'b1; wr_addr = 3'd4; wr_data = 16'd0;
      step();
      hi_wr = 1'b0;
      cnt_en = 1'b1;
      repeat (40) step();
      cnt_en = 1'b0;
      repeat (3) step();
      rd_addr = 3'd4;
      @(negedge clk);
      chk("R10 cascade count", {16'd0, hi_rd}, 32'd10);
      chk("R10 cascade model", {16'd0, hi_rd}, m_hits);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         cnt_en = ($urandom % 4) != 0;
         if (($urandom % 8) == 0) tin = ~tin;
         rd_addr = 3'($urandom % 5);
         wr_en = ($urandom % 8) == 0;
         wr_addr = 3'($urandom % 5);
         case (wr_addr)
            3'd0:    wr_data = 16'($urandom % 64);
            3'd3:    wr_data = 16'($urandom % 4);
            default: wr_data = 16'($urandom % 24);
         endcase
         step();
      end
      wr_en = 1'b0;
      cnt_en = 1'b0;
      step();
      summary();
   end

endmodule